// File: doc/BRIEF.md
# Pipelined Bus Burst Master

This block is the initiating side of a pipelined system bus. A local client hands it one command at a time: a start address, a beat count and a direction. The block then raises its bus request and waits for a grant. Once it owns the bus, it issues the transfer as a single beat or as an incrementing burst of up to 16 word-sized beats. Address and control for one beat are driven while the previous beat's data moves, so back-to-back beats take one cycle each when the slave does not stall.

The block follows the slave's handshake. When ready is low with an okay response, every address, control and write-data output holds still. A two-cycle failure response has three outcomes. Retry restarts the whole burst from its first beat. Split gives up ownership and resumes at the interrupted beat once the grant returns. Error abandons the command. Write data is fetched from the client by beat index, and read data is handed back with its beat index. A one-cycle pulse reports completion, and a different pulse reports an abort.

Top module: `burst_master`

## Requirements
- R1: After reset, bus_req, done and err are low, htrans is IDLE (2'b00) and cmd_ready is high.
- R2: A command accepted while cmd_ready is high raises bus_req in the next cycle. htrans stays IDLE until bus_grant has been sampled high on a clock edge with hready high. htrans is non-IDLE only while bus_req is high.
- R3: Beat i of a burst is addressed at start + 4*i. cmd_len holds the beat count minus one (0..15). The first beat is NONSEQ (2'b10) and every later beat is SEQ (2'b11). hburst is 0 when cmd_len is 0 and 1 otherwise.
- R4: Without wait states, successive beats are accepted on successive edges. The address of beat i+1 is presented during beat i's data phase. For writes, hwdata in beat i's data phase carries wd_data as presented when wd_idx was i.
- R5: While hready is low with an OKAY (2'b00) response, haddr, htrans and hwdata hold their values.
- R6: Each read beat that ends with hready high and OKAY pulses rd_valid for that cycle, with rd_idx set to the beat index and rd_data equal to hrdata.
- R7: One cycle after the last beat's data phase ends with OKAY, done pulses for one cycle, bus_req falls and htrans is IDLE.
- R8: On a RETRY (2'b10) response, htrans is IDLE in the response's second cycle. The burst then restarts at beat 0 with a NONSEQ at the start address.
- R9: On a SPLIT (2'b11) response, htrans is IDLE in the response's second cycle and ownership is released. The transfer resumes at the split beat with a NONSEQ once the grant is seen again, and done follows.
- R10: On an ERROR (2'b01) response, the command is abandoned. err pulses for one cycle, done does not, no further beat is issued, bus_req falls, and the next command runs normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Block idle, command taken |
| cmd_addr | input | AW | Start byte address |
| cmd_len | input | LENW | Beat count minus one |
| cmd_write | input | 1 | 1 = write, 0 = read |
| wd_idx | output | LENW | Beat whose write data is wanted |
| wd_data | input | DW | Write data for beat wd_idx |
| rd_valid | output | 1 | Read beat completed |
| rd_idx | output | LENW | Index of completed read beat |
| rd_data | output | DW | Read data |
| done | output | 1 | Command completed pulse |
| err | output | 1 | Command aborted pulse |
| bus_req | output | 1 | Bus request |
| bus_grant | input | 1 | Bus grant |
| haddr | output | AW | Address of current address phase |
| htrans | output | 2 | Transfer type: IDLE/NONSEQ/SEQ |
| hburst | output | 1 | 0 single, 1 incrementing burst |
| hwrite | output | 1 | Direction |
| hwdata | output | DW | Write data of current data phase |
| hready | input | 1 | Slave ready |
| hresp | input | 2 | Slave response |
| hrdata | input | DW | Read data |

## Verification
The bench builds the block with its default values: 32-bit address and data and a 16-beat limit. This lets a full-length burst run through the beat counter's top value, and it gives the 4-byte increment the bench predicts. A modelled slave with programmable wait states and a one-shot failure at a chosen beat produces retry, split and error mid-burst. Completed beats are logged with their cycle stamps, so the restart point, the resume point and back-to-back pipelining can all be compared against computed sequences.

// File: rtl/burst_master_pkg.sv
package burst_master_pkg;

    typedef enum logic [1:0] {
        TR_IDLE = 2'b00,
        TR_BUSY = 2'b01,
        TR_NSEQ = 2'b10,
        TR_SEQ  = 2'b11
    } trans_e;

    typedef enum logic [1:0] {
        RS_OKAY  = 2'b00,
        RS_ERROR = 2'b01,
        RS_RETRY = 2'b10,
        RS_SPLIT = 2'b11
    } resp_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_XFER = 1'b1
    } mst_state_e;

endpackage

// File: rtl/bm_addr_gen.sv
module bm_addr_gen #(
    parameter int AW    = 32,
    parameter int BEATW = 5,
    parameter int BYTES = 4
) (
    input  logic [AW-1:0]    base,
    input  logic [BEATW-1:0] beat,
    output logic [AW-1:0]    addr
);
    localparam int SH = $clog2(BYTES);

    // Beat index scaled by the transfer size.
    always_comb begin
        addr = base + (AW'(beat) << SH);
    end
endmodule

// File: rtl/bm_resp_class.sv
module bm_resp_class
    import burst_master_pkg::*;
(
    input  logic       dvalid,
    input  logic       hready,
    input  logic [1:0] hresp,
    output logic       beat_ok,
    output logic       fail_first,
    output logic       fail_end,
    output logic       is_retry,
    output logic       is_split,
    output logic       is_error
);
    logic not_ok;

    always_comb begin
        not_ok     = (hresp != RS_OKAY);
        beat_ok    = dvalid && hready && !not_ok;
        fail_first = dvalid && !hready && not_ok;
        fail_end   = dvalid && hready && not_ok;
        is_retry   = (hresp == RS_RETRY);
        is_split   = (hresp == RS_SPLIT);
        is_error   = (hresp == RS_ERROR);
    end
endmodule

// File: rtl/bm_own_track.sv
module bm_own_track (
    input  logic clk,
    input  logic rst_n,
    input  logic hready,
    input  logic grant,
    input  logic drop,
    output logic own
);
    logic own_d, own_q;

    always_comb begin
        own_d = own_q;
        if (drop)        own_d = 1'b0;
        else if (hready) own_d = grant;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) own_q <= 1'b0;
        else        own_q <= own_d;
    end

    assign own = own_q;
endmodule

// File: rtl/burst_master.sv
module burst_master
    import burst_master_pkg::*;
#(
    parameter int AW        = 32,
    parameter int DW        = 32,
    parameter int MAX_BEATS = 16,
    localparam int LENW     = $clog2(MAX_BEATS)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cmd_valid,
    output logic            cmd_ready,
    input  logic [AW-1:0]   cmd_addr,
    input  logic [LENW-1:0] cmd_len,
    input  logic            cmd_write,
    output logic [LENW-1:0] wd_idx,
    input  logic [DW-1:0]   wd_data,
    output logic            rd_valid,
    output logic [LENW-1:0] rd_idx,
    output logic [DW-1:0]   rd_data,
    output logic            done,
    output logic            err,
    output logic            bus_req,
    input  logic            bus_grant,
    output logic [AW-1:0]   haddr,
    output logic [1:0]      htrans,
    output logic            hburst,
    output logic            hwrite,
    output logic [DW-1:0]   hwdata,
    input  logic            hready,
    input  logic [1:0]      hresp,
    input  logic [DW-1:0]   hrdata
);
    localparam int BYTES = DW / 8;
    localparam int BEATW = $clog2(MAX_BEATS + 1);

    typedef struct packed {
        mst_state_e       st;
        logic [AW-1:0]    base;
        logic [LENW-1:0]  last;
        logic             wr;
        logic [BEATW-1:0] abeat;   // next beat for an address phase
        logic             fresh;   // next address phase is NONSEQ
        logic             dvalid;  // a beat is in its data phase
        logic [LENW-1:0]  dbeat;
        logic             cancel;  // second cycle of a failure response
        logic [DW-1:0]    wdata;
        logic             done;
        logic             err;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic own, drop, avail, accept;
    logic beat_ok, fail_first, fail_end, is_retry, is_split, is_error;

    bm_own_track u_own (
        .clk   (clk),
        .rst_n (rst_n),
        .hready(hready),
        .grant (bus_grant),
        .drop  (drop),
        .own   (own)
    );

    bm_resp_class u_resp (
        .dvalid    (ctl_q.dvalid),
        .hready    (hready),
        .hresp     (hresp),
        .beat_ok   (beat_ok),
        .fail_first(fail_first),
        .fail_end  (fail_end),
        .is_retry  (is_retry),
        .is_split  (is_split),
        .is_error  (is_error)
    );

    bm_addr_gen #(.AW(AW), .BEATW(BEATW), .BYTES(BYTES)) u_addr (
        .base(ctl_q.base),
        .beat(ctl_q.abeat),
        .addr(haddr)
    );

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.done = 1'b0;
        ctl_d.err  = 1'b0;
        drop       = 1'b0;
        avail      = (ctl_q.st == ST_XFER) && own && !ctl_q.cancel
                     && (ctl_q.abeat <= BEATW'(ctl_q.last));
        accept     = avail && hready;

        if (ctl_q.st == ST_IDLE) begin
            if (cmd_valid) begin
                ctl_d.st     = ST_XFER;
                ctl_d.base   = cmd_addr;
                ctl_d.last   = cmd_len;
                ctl_d.wr     = cmd_write;
                ctl_d.abeat  = '0;
                ctl_d.fresh  = 1'b1;
                ctl_d.dvalid = 1'b0;
                ctl_d.cancel = 1'b0;
            end
        end else begin
            // data phase finishing normally
            if (beat_ok) begin
                ctl_d.dvalid = 1'b0;
                if (ctl_q.dbeat == ctl_q.last) begin
                    ctl_d.st   = ST_IDLE;
                    ctl_d.done = 1'b1;
                end
            end
            // address phase taken: it becomes the next data phase
            if (accept) begin
                ctl_d.abeat  = ctl_q.abeat + 1'b1;
                ctl_d.fresh  = 1'b0;
                ctl_d.dvalid = 1'b1;
                ctl_d.dbeat  = ctl_q.abeat[LENW-1:0];
                if (ctl_q.wr) ctl_d.wdata = wd_data;
            end
            if (fail_first) ctl_d.cancel = 1'b1;
            if (fail_end) begin
                ctl_d.cancel = 1'b0;
                ctl_d.dvalid = 1'b0;
                ctl_d.fresh  = 1'b1;
                drop         = 1'b1;
                if (is_error) begin
                    ctl_d.st  = ST_IDLE;
                    ctl_d.err = 1'b1;
                end else if (is_split) begin
                    ctl_d.abeat = BEATW'(ctl_q.dbeat);
                end else if (is_retry) begin
                    ctl_d.abeat = '0;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    always_comb begin
        cmd_ready = (ctl_q.st == ST_IDLE);
        bus_req   = (ctl_q.st == ST_XFER);
        htrans    = avail ? (ctl_q.fresh ? TR_NSEQ : TR_SEQ) : TR_IDLE;
        hburst    = (ctl_q.last != '0);
        hwrite    = ctl_q.wr;
        hwdata    = ctl_q.wdata;
        wd_idx    = ctl_q.abeat[LENW-1:0];
        rd_valid  = beat_ok && !ctl_q.wr;
        rd_idx    = ctl_q.dbeat;
        rd_data   = hrdata;
        done      = ctl_q.done;
        err       = ctl_q.err;
    end
endmodule

// File: rtl/burst_master_chk.sv
module burst_master_chk
    import burst_master_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic [AW-1:0] haddr,
    input logic [1:0]    htrans,
    input logic          hburst,
    input logic [DW-1:0] hwdata,
    input logic          hready,
    input logic [1:0]    hresp,
    input logic          bus_req,
    input logic          done,
    input logic          err
);
    localparam int BYTES = DW / 8;

    assert_active_needs_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (htrans != TR_IDLE) |-> bus_req);

    assert_seq_in_burst_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (htrans == TR_SEQ) |-> hburst);

    assert_seq_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (htrans == TR_SEQ && hready) |=>
            (htrans != TR_SEQ || haddr == $past(haddr) + AW'(BYTES)));

    assert_hold_on_wait_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!hready && hresp == RS_OKAY && htrans != TR_IDLE) |=>
            ($stable(haddr) && $stable(htrans) && $stable(hwdata)));

    // covers R9 as well: both recoveries idle the bus in the second cycle
    assert_idle_after_fail_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!hready && hresp != RS_OKAY) |=> (htrans == TR_IDLE));

    assert_pulse_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && err));

    assert_err_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> $past(hready && hresp == RS_ERROR));
endmodule

bind burst_master burst_master_chk #(.AW(AW), .DW(DW)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .haddr  (haddr),
    .htrans (htrans),
    .hburst (hburst),
    .hwdata (hwdata),
    .hready (hready),
    .hresp  (hresp),
    .bus_req(bus_req),
    .done   (done),
    .err    (err)
);

// File: tb/burst_master_bench.sv
module burst_master_bench;
    localparam int AW = 32;
    localparam int DW = 32;
    localparam int LW = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic          cmd_valid = 1'b0;
    logic          cmd_ready;
    logic [AW-1:0] cmd_addr = '0;
    logic [LW-1:0] cmd_len = '0;
    logic          cmd_write = 1'b0;
    logic [LW-1:0] wd_idx;
    logic [DW-1:0] wd_data;
    logic          rd_valid;
    logic [LW-1:0] rd_idx;
    logic [DW-1:0] rd_data;
    logic          done, err, bus_req, bus_grant;
    logic [AW-1:0] haddr;
    logic [1:0]    htrans;
    logic          hburst, hwrite;
    logic [DW-1:0] hwdata;
    logic          hready;
    logic [1:0]    hresp;
    logic [DW-1:0] hrdata;

    logic          gnt_en = 1'b1;
    logic [31:0]   seed = '0;
    int            wait_n = 0;
    int            fail_at = -1;
    logic [1:0]    fail_kind = 2'b00;

    assign bus_grant = bus_req & gnt_en;
    assign wd_data   = seed + 32'h0000_0101 * {28'd0, wd_idx};

    burst_master u_burst_master (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_addr(cmd_addr),
        .cmd_len(cmd_len), .cmd_write(cmd_write),
        .wd_idx(wd_idx), .wd_data(wd_data),
        .rd_valid(rd_valid), .rd_idx(rd_idx), .rd_data(rd_data),
        .done(done), .err(err),
        .bus_req(bus_req), .bus_grant(bus_grant),
        .haddr(haddr), .htrans(htrans), .hburst(hburst), .hwrite(hwrite),
        .hwdata(hwdata), .hready(hready), .hresp(hresp), .hrdata(hrdata)
    );

    // ---------------- slave model ----------------
    logic [31:0] mem [0:255];
    logic        dp_valid, dp_write, err2;
    logic [31:0] dp_addr;
    int          wcnt, seen;
    assign hrdata = mem[dp_addr[9:2]];

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hready <= 1'b1; hresp <= 2'b00; dp_valid <= 1'b0; dp_write <= 1'b0;
            dp_addr <= '0; err2 <= 1'b0; wcnt <= 0; seen <= 0;
        end else if (hready) begin
            if (dp_valid && dp_write && hresp == 2'b00) mem[dp_addr[9:2]] <= hwdata;
            if (htrans[1]) begin
                dp_valid <= 1'b1; dp_addr <= haddr; dp_write <= hwrite;
                seen <= seen + 1;
                if (fail_kind != 2'b00 && seen == fail_at) begin
                    hready <= 1'b0; hresp <= fail_kind; err2 <= 1'b1;
                end else if (wait_n != 0) begin
                    hready <= 1'b0; hresp <= 2'b00; wcnt <= wait_n - 1;
                end else begin
                    hready <= 1'b1; hresp <= 2'b00;
                end
            end else begin
                dp_valid <= 1'b0; hready <= 1'b1; hresp <= 2'b00;
            end
        end else begin
            if (err2) begin hready <= 1'b1; err2 <= 1'b0; end
            else if (wcnt == 0) hready <= 1'b1;
            else wcnt <= wcnt - 1;
        end
    end

    // ---------------- monitor ----------------
    int          cyc = 0, mon_n = 0, rd_n = 0, dn_cnt = 0, er_cnt = 0, stab_viol = 0;
    logic [31:0] m_addr [0:511];
    logic [1:0]  m_tr   [0:511];
    logic        m_bu   [0:511];
    int          m_cyc  [0:511];
    logic [3:0]  r_idx  [0:511];
    logic [31:0] r_dat  [0:511];
    logic        p_lowok = 1'b0;
    logic [31:0] p_addr = '0, p_wd = '0;
    logic [1:0]  p_tr = '0;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (rst_n) begin
            if (htrans[1] && hready) begin
                m_addr[mon_n] <= haddr; m_tr[mon_n] <= htrans;
                m_bu[mon_n] <= hburst; m_cyc[mon_n] <= cyc;
                mon_n <= mon_n + 1;
            end
            if (rd_valid) begin
                r_idx[rd_n] <= rd_idx; r_dat[rd_n] <= rd_data; rd_n <= rd_n + 1;
            end
            if (done) dn_cnt <= dn_cnt + 1;
            if (err)  er_cnt <= er_cnt + 1;
            if (p_lowok && (haddr != p_addr || htrans != p_tr || hwdata != p_wd))
                stab_viol <= stab_viol + 1;
            p_lowok <= !hready && hresp == 2'b00 && htrans != 2'b00;
            p_addr <= haddr; p_tr <= htrans; p_wd <= hwdata;
        end
    end

    // ---------------- helpers ----------------
    int checks = 0, errors = 0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] expw(input logic [31:0] s, input int i);
        return s + 32'h0000_0101 * i;
    endfunction

    task automatic run_cmd(input logic [31:0] a, input int len, input bit wr);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_addr = a; cmd_len = LW'(len); cmd_write = wr;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic wait_end(input int d0, input int e0);
        for (int t = 0; t < 600 && dn_cnt == d0 && er_cnt == e0; t++) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    // check a logged beat sequence starting at log index m for beats b0..b1
    task automatic chk_seq(input string tag, input int m, input logic [31:0] base,
                           input int b0, input int b1, input bit burst);
        int bad = 0;
        for (int i = b0; i <= b1; i++) begin
            int k = m + i - b0;
            logic [1:0] et = (i == b0) ? 2'b10 : 2'b11;
            if (m_addr[k] != base + 4 * i || m_tr[k] != et || m_bu[k] != burst) bad++;
        end
        chk(bad == 0, tag, bad, 0);
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset();
        chk(bus_req == 1'b0 && done == 1'b0 && err == 1'b0, "R1 req/done/err after reset",
            {bus_req, done, err}, 0);
        chk(htrans == 2'b00 && cmd_ready == 1'b1, "R1 idle trans and ready", {htrans, cmd_ready}, 1);
    endtask

    task automatic t_grant_wait();
        int d0 = dn_cnt, e0 = er_cnt, m0 = mon_n;
        gnt_en = 1'b0; seed = 32'h1111_0000;
        run_cmd(32'h40, 0, 1'b1);
        repeat (4) @(negedge clk);
        chk(bus_req == 1'b1 && htrans == 2'b00, "R2 request held, bus idle before grant",
            {bus_req, htrans}, 3'b100);
        gnt_en = 1'b1;
        wait_end(d0, e0);
        chk(mon_n - m0 == 1, "R2 single beat issued after grant", mon_n - m0, 1);
        chk(m_addr[m0] == 32'h40 && m_tr[m0] == 2'b10, "R3 single NONSEQ at start", m_addr[m0], 32'h40);
        chk(m_bu[m0] == 1'b0, "R3 single transfer burst flag low", m_bu[m0], 0);
        chk(mem[8'h10] == 32'h1111_0000, "R4 single write data", mem[8'h10], 32'h1111_0000);
        chk(dn_cnt == d0 + 1, "R7 done pulse", dn_cnt - d0, 1);
        chk(bus_req == 1'b0 && htrans == 2'b00, "R7 released after done", {bus_req, htrans}, 0);
    endtask

    task automatic t_write16();
        int d0 = dn_cnt, e0 = er_cnt, m0 = mon_n, bad = 0;
        seed = 32'h2200_0000;
        run_cmd(32'h100, 15, 1'b1);
        wait_end(d0, e0);
        chk(mon_n - m0 == 16, "R3 sixteen beats", mon_n - m0, 16);
        chk_seq("R3 16-beat addresses and types", m0, 32'h100, 0, 15, 1'b1);
        for (int i = 1; i < 16; i++) if (m_cyc[m0 + i] != m_cyc[m0 + i - 1] + 1) bad++;
        chk(bad == 0, "R4 back-to-back address phases", bad, 0);
        bad = 0;
        for (int i = 0; i < 16; i++) if (mem[8'h40 + i] != expw(32'h2200_0000, i)) bad++;
        chk(bad == 0, "R4 burst write data per beat", bad, 0);
        chk(dn_cnt == d0 + 1 && er_cnt == e0, "R7 one done for burst", dn_cnt - d0, 1);
    endtask

    task automatic t_wait_write();
        int d0 = dn_cnt, e0 = er_cnt, m0 = mon_n, sv = stab_viol, bad = 0;
        seed = 32'h3300_0000; wait_n = 3;
        run_cmd(32'h300, 3, 1'b1);
        wait_end(d0, e0);
        wait_n = 0;
        chk(stab_viol == sv, "R5 outputs held during wait states", stab_viol - sv, 0);
        for (int i = 1; i < 4; i++) if (m_cyc[m0 + i] - m_cyc[m0 + i - 1] != 4) bad++;
        chk(bad == 0 && mon_n - m0 == 4, "R5 advance only after ready", bad, 0);
        bad = 0;
        for (int i = 0; i < 4; i++) if (mem[8'hC0 + i] != expw(32'h3300_0000, i)) bad++;
        chk(bad == 0, "R4 write data with waits", bad, 0);
    endtask

    task automatic t_read_waits();
        int d0 = dn_cnt, e0 = er_cnt, r0 = rd_n, bad = 0;
        wait_n = 1;
        run_cmd(32'h100, 7, 1'b0);
        wait_end(d0, e0);
        wait_n = 0;
        chk(rd_n - r0 == 8, "R6 eight read beats", rd_n - r0, 8);
        for (int i = 0; i < 8; i++)
            if (r_idx[r0 + i] != 4'(i) || r_dat[r0 + i] != expw(32'h2200_0000, i)) bad++;
        chk(bad == 0, "R6 read index and data", bad, 0);
        chk(dn_cnt == d0 + 1, "R7 done after read", dn_cnt - d0, 1);
    endtask

    task automatic t_retry();
        int d0 = dn_cnt, e0 = er_cnt, m0 = mon_n, bad = 0;
        seed = 32'h4400_0000; fail_kind = 2'b10; fail_at = seen + 2;
        run_cmd(32'h380, 3, 1'b1);
        wait_end(d0, e0);
        fail_kind = 2'b00;
        chk(mon_n - m0 == 7, "R8 beats before and after retry", mon_n - m0, 7);
        chk_seq("R8 first attempt", m0, 32'h380, 0, 2, 1'b1);
        chk_seq("R8 restart from beat 0", m0 + 3, 32'h380, 0, 3, 1'b1);
        for (int i = 0; i < 4; i++) if (mem[8'hE0 + i] != expw(32'h4400_0000, i)) bad++;
        chk(bad == 0 && dn_cnt == d0 + 1 && er_cnt == e0, "R8 completes after retry", bad, 0);
    endtask

    task automatic t_split();
        int d0 = dn_cnt, e0 = er_cnt, m0 = mon_n, r0 = rd_n, bad = 0;
        fail_kind = 2'b11; fail_at = seen + 1;
        run_cmd(32'h100, 3, 1'b0);
        wait_end(d0, e0);
        fail_kind = 2'b00;
        chk(mon_n - m0 == 5, "R9 beats around split", mon_n - m0, 5);
        chk_seq("R9 before split", m0, 32'h100, 0, 1, 1'b1);
        chk_seq("R9 resume at split beat", m0 + 2, 32'h100, 1, 3, 1'b1);
        for (int i = 0; i < 4; i++)
            if (r_idx[r0 + i] != 4'(i) || r_dat[r0 + i] != expw(32'h2200_0000, i)) bad++;
        chk(bad == 0 && rd_n - r0 == 4, "R9 read data after resume", bad, 0);
        chk(dn_cnt == d0 + 1, "R9 done after split", dn_cnt - d0, 1);
    endtask

    task automatic t_error();
        int d0 = dn_cnt, e0 = er_cnt, m0 = mon_n, r0 = rd_n;
        seed = 32'h5500_0000; fail_kind = 2'b01; fail_at = seen + 1;
        run_cmd(32'h200, 3, 1'b1);
        wait_end(d0, e0);
        fail_kind = 2'b00;
        repeat (3) @(negedge clk);
        chk(er_cnt == e0 + 1 && dn_cnt == d0, "R10 err pulse, no done", er_cnt - e0, 1);
        chk(mon_n - m0 == 2, "R10 no beat after error", mon_n - m0, 2);
        chk(bus_req == 1'b0 && htrans == 2'b00, "R10 bus released", {bus_req, htrans}, 0);
        chk(mem[8'h80] == 32'h5500_0000, "R10 beat before error written", mem[8'h80], 32'h5500_0000);
        d0 = dn_cnt; e0 = er_cnt; m0 = mon_n;
        run_cmd(32'h40, 0, 1'b0);
        wait_end(d0, e0);
        chk(dn_cnt == d0 + 1 && rd_n - r0 == 1 && r_dat[r0] == 32'h1111_0000,
            "R10 next command runs", r_dat[r0], 32'h1111_0000);
        chk(m_bu[m0] == 1'b0 && m_tr[m0] == 2'b10, "R3 single read flags", {m_bu[m0], m_tr[m0]}, 3'b010);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL R7 watchdog expired actual=%0d expected=0", 1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_grant_wait();
        t_write16();
        t_wait_write();
        t_read_waits();
        t_retry();
        t_split();
        t_error();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule